// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block is a host-bridge slave on an I/O bus. It gives software indirect access to device configuration space through two ports. The first is a 32-bit address register at I/O 0xCF8. The second is a four-byte data window at 0xCFC through 0xCFF.

Software first loads the address register with a target and sets its enable bit. It then reads or writes the data window. Each window access becomes one configuration request carrying:
- a bus number,
- a device/function number,
- a dword register index,
- byte enables derived from the window offset and the access size.

The request goes to a downstream responder. The I/O access stays stalled until that responder acknowledges it.

The I/O request side is a valid/ready channel. The requester raises `io_valid` and must hold `io_write`, `io_addr`, `io_size` and `io_wdata` stable until it sees `io_ready` high at a clock edge. That edge completes the access, and for reads `io_rdata` is valid in the same cycle. Accesses that need no configuration request complete in the cycle they are presented.

The downstream side is also valid/ready. `cfg_valid` is held with stable request fields until `cfg_ready` is seen. `cfg_rdata` and `cfg_unclaimed` are sampled in the same cycle as `cfg_ready`. Write data on `io_wdata` is right-justified: a byte uses bits 7:0 and a word uses bits 15:0. Read data on `io_rdata` is returned the same way, zero-extended. `io_size` encodes 0 = byte, 1 = word, 2 = dword and 3 = reserved.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register holds zero and `cfg_valid` is low.
- R2: A dword write at 0xCF8 stores bits 31:2 of the written value. A dword read there returns the stored value with bits 1:0 forced to zero. Saving and restoring the register this way never raises a configuration request.
- R3: A byte or word access anywhere in 0xCF8 to 0xCFB leaves the address register unchanged. Such a read returns 0xFFFFFFFF.
- R4: With address bit 31 (enable) clear, a data-window access completes in its own cycle without a request. A read returns 0xFFFFFFFF and a write is dropped.
- R5: A request takes its fields from the address register: `cfg_bus` = bits 23:16, `cfg_devfn` = bits 15:8 and `cfg_reg` = bits 7:2.
- R6: Byte enables are active high, with bit n meaning byte lane n. They follow the window offset:
  - A byte access at offset k gives 1<<k.
  - A word access at offset 0 gives 0x3, and at offset 2 gives 0xC.
  - A dword access at offset 0 gives 0xF.
  Write data is shifted to lane k (`cfg_wdata` = data << 8k). Read data is taken from lane k and right-justified.
- R7: A word access at an odd window offset, a dword access at a non-zero offset, and any reserved-size access issue no request. They complete at once, and a read returns 0xFFFFFFFF.
- R8: A request stays on `cfg_valid` with stable fields until `cfg_ready`. `io_ready` stays low for the whole wait and rises in the acknowledge cycle.
- R9: `cfg_type1` is 0 when the bus number is 0 and 1 for any other bus number.
- R10: A read the responder marks with `cfg_unclaimed` returns 0xFFFFFFFF.
- R11: An I/O address outside 0xCF8 to 0xCFF completes at once with no request. A read there returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O access presented |
| io_ready | output | 1 | I/O access completes this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Right-justified write data |
| io_rdata | output | 32 | Right-justified read data, valid with io_ready |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_ready | input | 1 | Responder accepts and completes the request |
| cfg_write | output | 1 | Request is a write |
| cfg_type1 | output | 1 | 1 = request for a non-zero bus |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Active-high byte enables |
| cfg_wdata | output | 32 | Lane-positioned write data |
| cfg_rdata | input | 32 | Lane-positioned read data, with cfg_ready |
| cfg_unclaimed | input | 1 | No device claimed the request, with cfg_ready |

## Verification
A corrupted address register would show on the very next dword read of 0xCF8. It would also show in the bus, device/function and register fields of the next request, one cycle after the window access is presented. A wrong lane decode would appear immediately on `cfg_be` and `cfg_wdata`, or as a shifted byte in the returned read data. A stuck or lost pending state would show as `io_ready` rising before the responder acknowledges, or never rising at all. Either case breaks the expected stall length on the first delayed request.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned LW   = $clog2(NB);

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef struct packed {
    logic          write;
    logic          type1;
    logic [7:0]    bus;
    logic [7:0]    devfn;
    logic [5:0]    dwidx;
    logic [NB-1:0] be;
    logic [DW-1:0] wdata;
    logic [LW-1:0] lane;
    logic [1:0]    size;
  } cfg_req_t;
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= {wr_data[DW-1:2], 2'b00};
  end
endmodule

// File: rtl/cfgp_lane_enc.sv
module cfgp_lane_enc
  import cfgp_pkg::*;
(
  input  logic [LW-1:0] offset,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  output logic          aligned,
  output logic [NB-1:0] be,
  output logic [DW-1:0] lane_wdata
);
  logic [DW-1:0] sized;

  always_comb begin
    aligned = 1'b0;
    be      = '0;
    sized   = '0;
    case (size)
      SZ_BYTE: begin
        aligned   = 1'b1;
        be        = NB'(1) << offset;
        sized[7:0] = wdata[7:0];
      end
      SZ_WORD: begin
        aligned     = ~offset[0];
        be          = NB'(3) << offset;
        sized[15:0] = wdata[15:0];
      end
      SZ_DWORD: begin
        aligned = (offset == '0);
        be      = '1;
        sized   = wdata;
      end
      default: aligned = 1'b0;
    endcase
    lane_wdata = sized << (8 * offset);
  end
endmodule

// File: rtl/cfgp_lane_ext.sv
module cfgp_lane_ext
  import cfgp_pkg::*;
(
  input  logic [LW-1:0] lane,
  input  logic [1:0]    size,
  input  logic [DW-1:0] lane_rdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] shifted;

  always_comb begin
    shifted = lane_rdata >> (8 * lane);
    rdata   = '0;
    for (int b = 0; b < NB; b++) begin
      if ((size == SZ_DWORD) || (b == 0) || (b == 1 && size == SZ_WORD))
        rdata[8*b +: 8] = shifted[8*b +: 8];
    end
  end
endmodule

// File: rtl/cfgp_req_hold.sv
module cfgp_req_hold
  import cfgp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  cfg_req_t req_in,
  input  logic     ack,
  output logic     busy,
  output cfg_req_t req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      req_q <= '0;
    end else if (!busy && launch) begin
      busy  <= 1'b1;
      req_q <= req_in;
    end else if (busy && ack) begin
      busy  <= 1'b0;
    end
  end

  // R8: a waiting request keeps every field until acknowledged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> busy && $stable(req_q));
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgp_pkg::*;
#(
  parameter int unsigned IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  output logic             io_ready,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic             cfg_valid,
  input  logic             cfg_ready,
  output logic             cfg_write,
  output logic             cfg_type1,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [5:0]       cfg_reg,
  output logic [NB-1:0]    cfg_be,
  output logic [DW-1:0]    cfg_wdata,
  input  logic [DW-1:0]    cfg_rdata,
  input  logic             cfg_unclaimed
);
  localparam int unsigned PW = IO_AW - LW;

  logic [LW-1:0] offset;
  logic          hit_addr, hit_data, addr_dw_acc, cfg_acc;
  logic          aligned, busy, launch, addr_wr;
  logic [NB-1:0] enc_be;
  logic [DW-1:0] enc_wdata, addr_q, ext_rdata;
  cfg_req_t      req_new, req_q;

  assign offset      = io_addr[LW-1:0];
  assign hit_addr    = io_addr[IO_AW-1:LW] == ADDR_PORT[IO_AW-1:LW];
  assign hit_data    = io_addr[IO_AW-1:LW] == DATA_PORT[IO_AW-1:LW];
  assign addr_dw_acc = hit_addr && io_size == SZ_DWORD && offset == '0;
  assign cfg_acc     = hit_data && aligned && addr_q[DW-1];
  assign launch      = io_valid && cfg_acc;
  assign addr_wr     = io_valid && !busy && addr_dw_acc && io_write;

  cfgp_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr), .wr_data(io_wdata), .addr_q(addr_q)
  );

  cfgp_lane_enc u_enc (
    .offset(offset), .size(io_size), .wdata(io_wdata),
    .aligned(aligned), .be(enc_be), .lane_wdata(enc_wdata)
  );

  always_comb begin
    req_new       = '0;
    req_new.write = io_write;
    req_new.bus   = addr_q[23:16];
    req_new.type1 = addr_q[23:16] != 8'd0;
    req_new.devfn = addr_q[15:8];
    req_new.dwidx = addr_q[7:2];
    req_new.be    = enc_be;
    req_new.wdata = enc_wdata;
    req_new.lane  = offset;
    req_new.size  = io_size;
  end

  cfgp_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .launch(launch), .req_in(req_new),
    .ack(cfg_ready), .busy(busy), .req_q(req_q)
  );

  cfgp_lane_ext u_ext (
    .lane(req_q.lane), .size(req_q.size), .lane_rdata(cfg_rdata), .rdata(ext_rdata)
  );

  assign cfg_valid = busy;
  assign cfg_write = req_q.write;
  assign cfg_type1 = req_q.type1;
  assign cfg_bus   = req_q.bus;
  assign cfg_devfn = req_q.devfn;
  assign cfg_reg   = req_q.dwidx;
  assign cfg_be    = req_q.be;
  assign cfg_wdata = req_q.wdata;

  always_comb begin
    if (busy) begin
      io_ready = cfg_ready;
      io_rdata = cfg_unclaimed ? '1 : ext_rdata;
    end else begin
      io_ready = io_valid && !cfg_acc;
      io_rdata = addr_dw_acc ? addr_q : '1;
    end
  end

  // R3: partial accesses at the address port leave the register alone
  a_r3_partial_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && io_ready && hit_addr && !addr_dw_acc |=> $stable(addr_q));
  // R4: no request starts unless the enable bit was set
  a_r4_enable_gates_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(addr_q[DW-1]));
  // R8: the I/O side is stalled while a request waits
  a_r8_io_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |-> !io_ready);
  // R6: byte enables are one, two or four lanes
  a_r6_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ($countones(cfg_be) == 1 || cfg_be == 4'h3 || cfg_be == 4'hC || cfg_be == 4'hF));
  // R9: request type follows the bus number
  a_r9_type_sel: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_type1 == (cfg_bus != 8'd0));
  // R10: an unclaimed completion reads all ones
  a_r10_unclaimed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready && cfg_unclaimed |-> io_rdata == '1);
  // R1: nothing pending in the cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !cfg_valid);
endmodule

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        cfg_valid, cfg_write, cfg_type1;
  logic        cfg_ready = 1'b0, cfg_unclaimed = 1'b0;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;

  always #5 clk = ~clk;

  cfg_port_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_ready(io_ready),
    .io_write(io_write), .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_write(cfg_write), .cfg_type1(cfg_type1), .cfg_bus(cfg_bus),
    .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_unclaimed(cfg_unclaimed)
  );

  typedef struct packed {
    logic        write;
    logic        type1;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [5:0]  dwidx;
    logic [3:0]  be;
    logic [31:0] wdata;
  } exp_req_t;

  exp_req_t    exp_q[$];
  int          n_checks = 0, n_fail = 0, n_reqs = 0;
  int          resp_delay = 0;
  logic [31:0] resp_data = '0;
  logic        resp_unclaimed = 1'b0;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor / responder: pops the expected request and compares
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      cfg_ready = 1'b0;
      cfg_unclaimed = 1'b0;
      if (cfg_valid) begin
        if (wait_cnt < resp_delay) wait_cnt++;
        else begin
          exp_req_t e;
          wait_cnt = 0;
          n_reqs++;
          if (exp_q.size() == 0) chk(1'b0, "R4 unexpected request", {24'd0, cfg_devfn}, 32'd0);
          else begin
            e = exp_q.pop_front();
            chk(cfg_write == e.write, "R5 write flag", {31'd0, cfg_write}, {31'd0, e.write});
            chk(cfg_bus == e.bus && cfg_devfn == e.devfn && cfg_reg == e.dwidx, "R5 fields",
                {8'd0, cfg_bus, cfg_devfn, 2'd0, cfg_reg}, {8'd0, e.bus, e.devfn, 2'd0, e.dwidx});
            chk(cfg_type1 == e.type1, "R9 type", {31'd0, cfg_type1}, {31'd0, e.type1});
            chk(cfg_be == e.be, "R6 byte enables", {28'd0, cfg_be}, {28'd0, e.be});
            if (e.write) chk(cfg_wdata == e.wdata, "R6 lane write data", cfg_wdata, e.wdata);
          end
          cfg_ready = 1'b1;
          cfg_rdata = resp_data;
          cfg_unclaimed = resp_unclaimed;
        end
      end
    end
  end

  // Driver: presents one access and waits for completion
  task automatic io(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                    input logic [31:0] wd, output logic [31:0] rd, output int stall);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
    stall = 0;
    forever begin
      #2;
      if (io_ready) begin
        rd = io_rdata;
        @(negedge clk);
        io_valid = 1'b0;
        break;
      end
      stall++;
      @(negedge clk);
    end
  endtask

  task automatic push(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                      input logic [5:0] idx, input logic [3:0] be, input logic [31:0] wd);
    exp_req_t e;
    e.write = wr; e.type1 = (bus != 0); e.bus = bus; e.devfn = devfn;
    e.dwidx = idx; e.be = be; e.wdata = wd;
    exp_q.push_back(e);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, saved;
    int st, base;
    repeat (3) @(negedge clk);
    chk(cfg_valid == 1'b0, "R1 no request in reset", {31'd0, cfg_valid}, 32'd0);
    rst_n = 1'b1;
    io(0, 16'hCF8, 2, 0, rd, st);
    chk(rd == 32'h0, "R1 address register reset", rd, 32'h0);

    // R2 write/read back
    io(1, 16'hCF8, 2, 32'h8000_0000, rd, st);
    io(0, 16'hCF8, 2, 0, rd, st);
    chk(rd == 32'h8000_0000, "R2 readback enable", rd, 32'h8000_0000);
    io(1, 16'hCF8, 2, 32'h1234_5677, rd, st);
    io(0, 16'hCF8, 2, 0, rd, st);
    chk(rd == 32'h1234_5674, "R2 low bits zero", rd, 32'h1234_5674);

    // R4 disabled window
    base = n_reqs;
    io(0, 16'hCFC, 2, 0, rd, st);
    chk(rd == 32'hFFFF_FFFF, "R4 disabled read", rd, 32'hFFFF_FFFF);
    chk(st == 0, "R4 no stall", st, 0);
    io(1, 16'hCFD, 0, 32'h11, rd, st);
    repeat (3) @(negedge clk);
    chk(n_reqs == base, "R4 write dropped", n_reqs, base);

    // R3 partial accesses at address port
    io(1, 16'hCFB, 0, 32'h01, rd, st);
    io(1, 16'hCF8, 1, 32'hBEEF, rd, st);
    io(0, 16'hCFA, 0, 0, rd, st);
    chk(rd == 32'hFFFF_FFFF, "R3 partial read ones", rd, 32'hFFFF_FFFF);
    io(0, 16'hCF8, 2, 0, rd, st);
    chk(rd == 32'h1234_5674, "R3 register unchanged", rd, 32'h1234_5674);

    // R5/R6/R8 dword read bus 0 with delay
    io(1, 16'hCF8, 2, 32'h8000_1810, rd, st);
    resp_data = 32'hAABB_CCDD; resp_delay = 3;
    push(0, 8'h00, 8'h18, 6'h04, 4'hF, 0);
    io(0, 16'hCFC, 2, 0, rd, st);
    chk(rd == 32'hAABB_CCDD, "R6 dword read", rd, 32'hAABB_CCDD);
    chk(st == 4, "R8 stall length", st, 4);
    resp_delay = 0;
    push(0, 8'h00, 8'h18, 6'h04, 4'h4, 0);
    io(0, 16'hCFE, 0, 0, rd, st);
    chk(rd == 32'h0000_00BB, "R6 byte read lane 2", rd, 32'hBB);
    push(0, 8'h00, 8'h18, 6'h04, 4'hC, 0);
    io(0, 16'hCFE, 1, 0, rd, st);
    chk(rd == 32'h0000_AABB, "R6 word read upper", rd, 32'hAABB);
    push(1, 8'h00, 8'h18, 6'h04, 4'h2, 32'h0000_5A00);
    io(1, 16'hCFD, 0, 32'hFFFF_FF5A, rd, st);
    push(1, 8'h00, 8'h18, 6'h04, 4'h3, 32'h0000_1234);
    io(1, 16'hCFC, 1, 32'h9999_1234, rd, st);
    push(0, 8'h00, 8'h18, 6'h04, 4'h8, 0);
    io(0, 16'hCFF, 0, 0, rd, st);
    chk(rd == 32'h0000_00AA, "R6 byte read lane 3", rd, 32'hAA);

    // R9/R5 non-zero bus write
    io(1, 16'hCF8, 2, 32'h8005_2A3C, rd, st);
    resp_delay = 2;
    push(1, 8'h05, 8'h2A, 6'h0F, 4'hF, 32'hDEAD_BEEF);
    io(1, 16'hCFC, 2, 32'hDEAD_BEEF, rd, st);
    chk(st == 3, "R8 write stall", st, 3);

    // R10 unclaimed
    resp_delay = 0; resp_unclaimed = 1'b1;
    push(0, 8'h05, 8'h2A, 6'h0F, 4'h1, 0);
    io(0, 16'hCFC, 0, 0, rd, st);
    chk(rd == 32'hFFFF_FFFF, "R10 unclaimed read", rd, 32'hFFFF_FFFF);
    resp_unclaimed = 1'b0;

    // R7 misaligned / reserved, R11 outside range
    base = n_reqs;
    io(0, 16'hCFD, 1, 0, rd, st);
    chk(rd == 32'hFFFF_FFFF && st == 0, "R7 odd word", rd, 32'hFFFF_FFFF);
    io(0, 16'hCFE, 2, 0, rd, st);
    chk(rd == 32'hFFFF_FFFF, "R7 offset dword", rd, 32'hFFFF_FFFF);
    io(1, 16'hCFC, 3, 32'h1, rd, st);
    io(0, 16'h0080, 2, 0, rd, st);
    chk(rd == 32'hFFFF_FFFF && st == 0, "R11 outside range", rd, 32'hFFFF_FFFF);
    io(1, 16'hCF0, 2, 32'h5, rd, st);

    // R2 save/restore without side effects
    io(0, 16'hCF8, 2, 0, rd, st); saved = rd;
    io(1, 16'hCF8, 2, 32'h8000_0000, rd, st);
    io(1, 16'hCF8, 2, saved, rd, st);
    io(0, 16'hCF8, 2, 0, rd, st);
    chk(rd == 32'h8005_2A3C, "R2 restore", rd, 32'h8005_2A3C);
    repeat (3) @(negedge clk);
    chk(n_reqs == base, "R7 R11 R2 no requests", n_reqs, base);
    chk(exp_q.size() == 0, "R5 all expected requests seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule